// File: doc/BRIEF.md
# Masked-Match Memory Bank Decoder

This block takes a physical address and decides which of four programmable memory banks claims it. Each bank descriptor holds an enable bit and two key/match pairs. One pair covers a high address field and the other covers a low address field. A key bit that is set makes that address bit a don't-care position. A bank claims the address only when it is enabled and both fields agree with its match values at every position the key does not mask. When several banks claim the same address, the lowest-numbered bank wins.

The descriptors are loaded one at a time through a small register write port. A lookup is started by an address strobe. One cycle later the block returns a valid pulse together with the result: the hit flag, the winning bank number, and that bank's derived geometry. The geometry is the base address, the interleave factor and the size. The low-field key encodes the interleave factor, and the interleave factor in turn divides the bank size.

Top module: `bank_decoder`

## Requirements
- R1: After reset, `out_vld` and `hit` are low and every bank is disabled, so any lookup misses.
- R2: When `cfg_we` is high, `cfg_data` is stored into bank `cfg_idx`. The word layout is: bit 32 enable, bits 31:20 high key, bits 19:8 high match, bits 7:4 low key, bits 3:0 low match.
- R3: A disabled bank never claims an address.
- R4: The high field is `addr[37:26]`. It agrees with a bank when every bit that differs from the high match is set in the high key.
- R5: The low field is `addr[9:6]` and is compared against the low key and low match in the same way. A bank claims the address only when both fields agree.
- R6: When more than one enabled bank claims the address, the lowest bank number is reported.
- R7: `ilv` reports the interleave factor derived from the low key: 4'hF gives 1, 4'hE gives 2, 4'hC gives 4, 4'h8 gives 8, 4'h0 gives 16, and any other key gives 1.
- R8: `base` equals the high match with its high-key bits cleared, shifted left by 26.
- R9: `size` equals (high key bits 9:0 plus one) shifted left by 26, divided by the interleave factor. High key bits 11:10 do not affect it.
- R10: `out_vld` is high exactly in the cycle after a cycle with `req` high, and the results are valid in that cycle.
- R11: On a miss, `hit`, `bank`, `base`, `size` and `ilv` are all zero.
- R12: A lookup in the same cycle as a descriptor write sees the old descriptor. The write takes effect from the next lookup.
- R13: Address bits outside the two fields have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Descriptor write enable |
| cfg_idx | input | 2 | Bank number to write |
| cfg_data | input | 33 | Descriptor word |
| req | input | 1 | Lookup strobe |
| addr | input | 40 | Physical address to decode |
| out_vld | output | 1 | Result valid pulse |
| hit | output | 1 | An enabled bank claimed the address |
| bank | output | 2 | Winning bank number |
| base | output | 40 | Base address of the winning bank |
| size | output | 40 | Size of the winning bank in bytes |
| ilv | output | 5 | Interleave factor of the winning bank |

## Verification
The bench builds the block with its default parameters. These are a 40-bit address, four banks, the high field at bit 26 and the low field at bit 6, with a 10-bit size key. With these values every interleave code and the widest size, 2^36, fit within the 40-bit outputs.

The configuration is chosen so that banks overlap, which makes the priority order visible. Some addresses differ from a bank's match only in masked positions, and others differ in a position the key does not mask. Filler bits are set outside both fields to show that they are ignored. A full-width high key shows that bits 11:10 are dropped from the size.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
   localparam int U_W = 12;
   localparam int L_W = 4;

   typedef struct packed {
      logic           en;
      logic [U_W-1:0] ukey;
      logic [U_W-1:0] umat;
      logic [L_W-1:0] lkey;
      logic [L_W-1:0] lmat;
   } bank_cfg_t;

   localparam int CFG_W = $bits(bank_cfg_t);
endpackage

// File: rtl/bdec_cfg_store.sv
module bdec_cfg_store
   import bdec_pkg::*;
#(
   parameter int NBANK = 4,
   localparam int IDX_W = $clog2(NBANK)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [IDX_W-1:0]      idx,
   input  bank_cfg_t             wdata,
   output bank_cfg_t [NBANK-1:0] cfg
);
   for (genvar b = 0; b < NBANK; b++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg[b] <= '0;
         end else if (we && (idx == IDX_W'(b))) begin
            cfg[b] <= wdata;
         end
      end

      // R2: an unselected slot keeps its contents
      a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && (idx == IDX_W'(b))) |=> $stable(cfg[b]));
   end
endmodule

// File: rtl/bdec_match.sv
module bdec_match
   import bdec_pkg::*;
(
   input  bank_cfg_t      cfg,
   input  logic [U_W-1:0] ufld,
   input  logic [L_W-1:0] lfld,
   output logic           claim
);
   logic [U_W-1:0] udiff;
   logic [L_W-1:0] ldiff;

   always_comb begin
      udiff = (ufld ^ cfg.umat) & ~cfg.ukey;
      ldiff = (lfld ^ cfg.lmat) & ~cfg.lkey;
      claim = cfg.en && (udiff == '0) && (ldiff == '0);
   end
endmodule

// File: rtl/bdec_geom.sv
module bdec_geom
   import bdec_pkg::*;
#(
   parameter int ADDR_W = 40,
   parameter int U_LO   = 26,
   parameter int SZ_W   = 10,
   localparam int LG_W  = $clog2(L_W + 1),
   localparam int IL_W  = L_W + 1
) (
   input  bank_cfg_t         cfg,
   output logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] size,
   output logic [IL_W-1:0]   ilv
);
   logic [LG_W-1:0] lg;
   logic [L_W-1:0]  pat;

   // the key codes are runs of ones followed by k zeros, k = 0..L_W
   always_comb begin
      lg  = '0;
      pat = '0;
      for (int k = 1; k <= L_W; k++) begin
         pat = {L_W{1'b1}} << k;
         if (cfg.lkey == pat) lg = LG_W'(k);
      end
   end

   always_comb begin
      ilv  = IL_W'(1) << lg;
      base = ADDR_W'(cfg.umat & ~cfg.ukey) << U_LO;
      size = ((ADDR_W'(cfg.ukey[SZ_W-1:0]) + ADDR_W'(1)) << U_LO) >> lg;
   end
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
   import bdec_pkg::*;
#(
   parameter int ADDR_W = 40,
   parameter int NBANK  = 4,
   parameter int U_LO   = 26,
   parameter int L_LO   = 6,
   parameter int SZ_W   = 10,
   localparam int IDX_W = $clog2(NBANK),
   localparam int IL_W  = L_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [CFG_W-1:0]  cfg_data,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   output logic              out_vld,
   output logic              hit,
   output logic [IDX_W-1:0]  bank,
   output logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] size,
   output logic [IL_W-1:0]   ilv
);
   if (NBANK < 2) begin : g_bad_nbank
      $error("NBANK must be at least 2");
   end
   if (U_LO + U_W > ADDR_W) begin : g_bad_ufld
      $error("high field exceeds the address width");
   end
   if (L_LO + L_W > U_LO) begin : g_bad_lfld
      $error("low field overlaps the high field");
   end
   if (SZ_W > U_W || SZ_W + 1 + U_LO > ADDR_W) begin : g_bad_size
      $error("size key does not fit");
   end

   bank_cfg_t [NBANK-1:0] cfg_q;
   logic      [NBANK-1:0] claim;
   logic      [U_W-1:0]   ufld;
   logic      [L_W-1:0]   lfld;
   logic                  found;
   logic      [IDX_W-1:0] win;
   bank_cfg_t             win_cfg;
   logic [ADDR_W-1:0]     g_base;
   logic [ADDR_W-1:0]     g_size;
   logic [IL_W-1:0]       g_ilv;
   logic                  unused_addr;

   assign ufld        = addr[U_LO +: U_W];
   assign lfld        = addr[L_LO +: L_W];
   assign unused_addr = ^addr;

   bdec_cfg_store #(.NBANK(NBANK)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .idx   (cfg_idx),
      .wdata (bank_cfg_t'(cfg_data)),
      .cfg   (cfg_q)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      bdec_match u_match (
         .cfg   (cfg_q[b]),
         .ufld  (ufld),
         .lfld  (lfld),
         .claim (claim[b])
      );

      // R3: a disabled slot never claims
      a_r3_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg_q[b].en |-> !claim[b]);
   end

   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int i = 0; i < NBANK; i++) begin
         if (claim[i] && !found) begin
            found = 1'b1;
            win   = IDX_W'(i);
         end
      end
   end

   assign win_cfg = cfg_q[win];

   bdec_geom #(.ADDR_W(ADDR_W), .U_LO(U_LO), .SZ_W(SZ_W)) u_geom (
      .cfg  (win_cfg),
      .base (g_base),
      .size (g_size),
      .ilv  (g_ilv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         hit     <= 1'b0;
         bank    <= '0;
         base    <= '0;
         size    <= '0;
         ilv     <= '0;
      end else begin
         out_vld <= req;
         if (req) begin
            hit  <= found;
            bank <= found ? win    : '0;
            base <= found ? g_base : '0;
            size <= found ? g_size : '0;
            ilv  <= found ? g_ilv  : '0;
         end else begin
            hit  <= 1'b0;
         end
      end
   end

   // R6: the winner claims and no lower slot does
   a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> claim[win] && ((claim & ((NBANK'(1) << win) - NBANK'(1))) == '0));

   // R10: result pulse follows the strobe by one cycle
   a_r10_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> out_vld);
   a_r10_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !out_vld);
   a_r10_hit_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> !hit);

   // R11: a miss reports all zeros
   a_r11_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !hit) |-> (bank == '0 && base == '0 && size == '0 && ilv == '0));

   // R7: a hit reports a power-of-two interleave
   a_r7_ilv_pow2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && hit) |-> ($countones(ilv) == 1));

   // R9: a hit bank never has zero size
   a_r9_size_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && hit) |-> (size != '0));
endmodule

// File: tb/sim_bank_decoder.sv
module sim_bank_decoder;
   localparam int CLK_P = 10;
   localparam logic [39:0] FILL = 40'hC0_03FF_FC3F;
   localparam int NV = 11;
   // row: {high[11:0], low[3:0], hit, bank[1:0], fill}
   localparam logic [19:0] VEC [NV] = '{
      {12'h001, 4'h0, 1'b1, 2'd0, 1'b0},
      {12'h001, 4'hF, 1'b1, 2'd0, 1'b1},
      {12'h005, 4'h1, 1'b1, 2'd1, 1'b0},
      {12'h007, 4'hF, 1'b1, 2'd1, 1'b1},
      {12'h005, 4'h5, 1'b1, 2'd1, 1'b0},
      {12'h006, 4'h4, 1'b0, 2'd0, 1'b1},
      {12'h00A, 4'h5, 1'b1, 2'd2, 1'b0},
      {12'h00A, 4'h4, 1'b0, 2'd0, 1'b1},
      {12'h010, 4'h5, 1'b0, 2'd0, 1'b0},
      {12'h000, 4'h5, 1'b1, 2'd2, 1'b1},
      {12'h801, 4'h0, 1'b0, 2'd0, 1'b0}
   };
   localparam logic [39:0] EXP_BASE [3] = '{40'h0004000000, 40'h0010000000, 40'h0};
   localparam logic [39:0] EXP_SIZE [3] = '{40'h0004000000, 40'h0008000000, 40'h0004000000};
   localparam logic [4:0]  EXP_ILV  [3] = '{5'd1, 5'd2, 5'd16};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [32:0] cfg_data = '0;
   logic        req = 1'b0;
   logic [39:0] addr = '0;
   logic        out_vld, hit;
   logic [1:0]  bank;
   logic [39:0] base, size;
   logic [4:0]  ilv;
   int total = 0;
   int bad = 0;

   always #(CLK_P/2) clk = ~clk;

   bank_decoder u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .req(req), .addr(addr), .out_vld(out_vld),
      .hit(hit), .bank(bank), .base(base), .size(size), .ilv(ilv)
   );

   function automatic logic [32:0] mk(input logic en, input logic [11:0] uk,
      input logic [11:0] um, input logic [3:0] lk, input logic [3:0] lm);
      return {en, uk, um, lk, lm};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] i, input logic [32:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = i; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic look(input logic [11:0] u, input logic [3:0] l, input logic f);
      @(negedge clk);
      req = 1'b1;
      addr = (40'(u) << 26) | (40'(l) << 6) | (f ? FILL : 40'h0);
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic expect_res(input string tag, input logic h, input logic [1:0] b,
      input logic [39:0] eb, input logic [39:0] es, input logic [4:0] ei);
      chk({tag, " vld"}, 64'(out_vld), 64'(1'b1));
      chk({tag, " hit"}, 64'(hit), 64'(h));
      chk({tag, " bank"}, 64'(bank), 64'(b));
      chk({tag, " base"}, 64'(base), 64'(eb));
      chk({tag, " size"}, 64'(size), 64'(es));
      chk({tag, " ilv"}, 64'(ilv), 64'(ei));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P*2);
      // R1: reset state
      chk("R1 vld at reset", 64'(out_vld), 0);
      chk("R1 hit at reset", 64'(hit), 0);
      @(negedge clk);
      rst_n = 1'b1;
      look(12'h001, 4'h0, 1'b0);
      expect_res("R1 all banks off", 1'b0, 2'd0, 0, 0, 0);

      // R2: load descriptors
      wr(2'd0, mk(1'b1, 12'h000, 12'h001, 4'hF, 4'h0));
      wr(2'd1, mk(1'b1, 12'h003, 12'h004, 4'hE, 4'h1));
      wr(2'd2, mk(1'b1, 12'h00F, 12'h004, 4'h0, 4'h5));
      wr(2'd3, mk(1'b0, 12'hFFF, 12'h000, 4'h3, 4'h0));

      // R3 R4 R5 R6 R7 R8 R9 R11 R13: table walk
      for (int i = 0; i < NV; i++) begin
         logic [1:0] eb;
         logic       eh;
         eh = VEC[i][3];
         eb = VEC[i][2:1];
         look(VEC[i][19:8], VEC[i][7:4], VEC[i][0]);
         if (eh)
            expect_res($sformatf("R4/R5/R6/R13 row %0d", i), 1'b1, eb,
               EXP_BASE[eb], EXP_SIZE[eb], EXP_ILV[eb]);
         else
            expect_res($sformatf("R3/R11 row %0d", i), 1'b0, 2'd0, 0, 0, 0);
      end

      // R10: pulse drops the cycle after
      @(negedge clk);
      chk("R10 vld pulse ends", 64'(out_vld), 0);

      // R9: full-width high key, bits 11:10 ignored; R7 odd key gives 1
      wr(2'd3, mk(1'b1, 12'hFFF, 12'h000, 4'h3, 4'h0));
      look(12'h801, 4'h0, 1'b0);
      expect_res("R9 wide key", 1'b1, 2'd3, 0, 40'h1000000000, 5'd1);

      // R12: same-cycle write sees old descriptor
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 2'd0; cfg_data = mk(1'b0, 12'h000, 12'h001, 4'hF, 4'h0);
      req = 1'b1; addr = 40'(12'h001) << 26;
      @(negedge clk);
      cfg_we = 1'b0; req = 1'b0;
      expect_res("R12 old descriptor", 1'b1, 2'd0, 40'h0004000000, 40'h0004000000, 5'd1);
      look(12'h001, 4'h0, 1'b0);
      expect_res("R12 R3 new descriptor", 1'b1, 2'd3, 0, 40'h1000000000, 5'd1);

      // R7: remaining interleave codes
      wr(2'd3, mk(1'b1, 12'hFFF, 12'h000, 4'hC, 4'h0));
      look(12'h801, 4'h0, 1'b0);
      expect_res("R7 ilv4", 1'b1, 2'd3, 0, 40'h0400000000, 5'd4);
      look(12'h801, 4'h1, 1'b0);
      expect_res("R5 low bit cared", 1'b0, 2'd0, 0, 0, 0);
      wr(2'd3, mk(1'b1, 12'hFFF, 12'h000, 4'h8, 4'h0));
      look(12'h801, 4'h0, 1'b0);
      expect_res("R7 ilv8", 1'b1, 2'd3, 0, 40'h0200000000, 5'd8);
      wr(2'd3, mk(1'b1, 12'hFFF, 12'h000, 4'h0, 4'h0));
      look(12'h801, 4'h0, 1'b0);
      expect_res("R7 ilv16", 1'b1, 2'd3, 0, 40'h0100000000, 5'd16);

      // R8: key bits cleared out of the base
      wr(2'd3, mk(1'b1, 12'h0F0, 12'h0FF, 4'hF, 4'h0));
      look(12'h00F, 4'h0, 1'b0);
      expect_res("R8 base masked", 1'b1, 2'd3, 40'h003C000000, 40'h03C4000000, 5'd1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule